// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block sits between functional units that finish out of program order and the architectural register file. Issue logic allocates one slot per instruction in program order and receives a slot tag back. Functional units later return results by tag, in any order and up to one per completion port per cycle. The buffer holds each result until every older instruction has retired. It then hands the results to the register file one per cycle, strictly oldest first.

Each source operand of a newly issued instruction is looked up in the buffer. The youngest occupied slot that writes the same register is the producer. If that slot holds its result, the result is forwarded. If it does not, the caller receives the producer's tag and waits. If no slot matches, the register-file value supplied with the lookup passes through.

Some results carry an exception flag. When such a result becomes the oldest entry, it is not retired. Instead the block reports the instruction's PC for one cycle and empties itself. The register file then holds exactly the effects of the instructions before the faulting one, so that instruction can be restarted.

Back-pressure rules:
- Allocation is a valid/ready handshake. `alloc_ready` is low while all slots are occupied and during a fault cycle.
- Retirement is a valid/ready handshake. `commit_valid` with its destination and data holds steady until `commit_ready` is seen high.
- Completions and lookups are always accepted and have no ready signal.

Top module: `inorder_retire_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready`=1, `alloc_tag`=0, `commit_valid`=0, `fault_valid`=0, and every lookup misses.
- R2: An allocation is accepted when `alloc_valid` and `alloc_ready` are both high. `alloc_tag` shows the slot the next allocation receives. Tags run 0,1,…,DEPTH-1 and then wrap to 0, advancing by one per accepted allocation.
- R3: `alloc_ready` is low while all DEPTH slots are occupied, and an allocation offered then has no effect. A retirement frees its slot for allocation only from the following cycle.
- R4: A completion on port p (`cmp_valid[p]`, tag in bits [p*IDX_W +: IDX_W], data in bits [p*DATA_W +: DATA_W]) marks an occupied slot done and stores its data and exception flag. Completions may arrive in any order, on several ports in one cycle. A completion naming an unoccupied slot is ignored.
- R5: `commit_valid` is high exactly when the oldest slot is done without exception, and it presents that slot's destination and data. The slot retires when `commit_ready` is high. A younger done slot never retires before the oldest one.
- R6: While `commit_valid` is high and `commit_ready` is low, nothing retires and the commit outputs hold their values.
- R7: Lookup port s compares register `src_reg[s*REG_W +: REG_W]` with the occupied slots. Among the matches the youngest wins: `src_hit`=1 and `src_tag` gives its slot. If that slot is done, `src_ready`=1 and `src_value` is its result; otherwise `src_ready`=0.
- R8: When no occupied slot matches, `src_hit`=0, `src_ready`=1, and `src_value` equals the `src_rf_data` field of that port.
- R9: When the oldest slot is done with its exception flag set, `fault_valid` is high with that slot's PC for one cycle. Nothing retires, and allocations and completions in that cycle are ignored. From the next cycle the buffer is empty and `alloc_tag` is 0. An exception on a younger slot has no effect until that slot is oldest.
- R10: Lookups see the buffer as it stood at the start of the cycle. A completion shows up one cycle later, and a slot retiring in the current cycle still forwards its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | Allocation accepted this cycle if requested |
| alloc_dest | input | REG_W | Destination register of the allocating instruction |
| alloc_pc | input | PC_W | PC of the allocating instruction |
| alloc_tag | output | IDX_W | Slot the next allocation receives |
| cmp_valid | input | NCMP | Per-port completion strobe |
| cmp_tag | input | NCMP*IDX_W | Per-port slot tag of the result |
| cmp_data | input | NCMP*DATA_W | Per-port result value |
| cmp_exc | input | NCMP | Per-port exception flag |
| src_reg | input | NSRC*REG_W | Per-port source register to look up |
| src_rf_data | input | NSRC*DATA_W | Per-port register-file value used on a miss |
| src_hit | output | NSRC | A buffered producer exists |
| src_ready | output | NSRC | The operand value is usable |
| src_tag | output | NSRC*IDX_W | Slot of the youngest producer |
| src_value | output | NSRC*DATA_W | Forwarded or register-file value |
| commit_valid | output | 1 | Oldest result ready to retire |
| commit_ready | input | 1 | Register file accepts the retirement |
| commit_dest | output | REG_W | Register written by the retirement |
| commit_data | output | DATA_W | Value written by the retirement |
| fault_valid | output | 1 | Oldest slot faulted; buffer empties |
| fault_pc | output | PC_W | PC of the faulting instruction |

## Verification
A vector table drives a short program with two producers of the same register. One completion arrives late and the buffer retires under a stalled register file. This separates forwarding of the youngest producer from an older one, and an unfinished producer from a finished one. Directed sequences then complete slots out of order on both ports at once and send a completion to an empty slot. They also fill the ring to wrap the tags and offer an allocation while full. These patterns tell in-order retirement apart from retirement in completion order, and a refused allocation apart from one that overwrote an occupied slot. Two fault cases check that a faulting oldest entry empties the buffer and reports its PC, and that an exception on a younger entry waits until that entry is oldest.

// File: rtl/irb_pkg.sv
package irb_pkg;

  // Outcome of one operand search through the buffer.
  typedef enum logic [1:0] {
    LK_MISS = 2'd0,  // no occupied slot writes the register
    LK_WAIT = 2'd1,  // youngest producer has not finished
    LK_HIT  = 2'd2   // youngest producer holds its result
  } lookup_e;

endpackage

// File: rtl/irb_ptrs.sv
// Ring pointers and occupancy count. DEPTH must be a power of two so that
// pointer arithmetic wraps by truncation.
module irb_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_alloc,
  input  logic             do_commit,
  input  logic             do_flush,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (do_flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (do_alloc)  tail <= tail + 1'b1;
      if (do_commit) head <= head + 1'b1;
      count <= count + CNT_W'(do_alloc) - CNT_W'(do_commit);
    end
  end

  assign full = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/irb_store.sv
// Slot array: per-slot state flags plus payload, written by allocation,
// completion ports, retirement and flush.
module irb_store #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int NCMP   = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              do_alloc,
  input  logic [IDX_W-1:0]                  tail,
  input  logic [REG_W-1:0]                  alloc_dest,
  input  logic [PC_W-1:0]                   alloc_pc,
  input  logic [NCMP-1:0]                   cmp_valid,
  input  logic [NCMP-1:0][IDX_W-1:0]        cmp_tag,
  input  logic [NCMP-1:0][DATA_W-1:0]       cmp_data,
  input  logic [NCMP-1:0]                   cmp_exc,
  input  logic                              do_commit,
  input  logic [IDX_W-1:0]                  head,
  input  logic                              do_flush,
  output logic [DEPTH-1:0]                  vld,
  output logic [DEPTH-1:0]                  dne,
  output logic [DEPTH-1:0]                  exc,
  output logic [DEPTH-1:0][REG_W-1:0]       dst,
  output logic [DEPTH-1:0][DATA_W-1:0]      dat,
  output logic [DEPTH-1:0][PC_W-1:0]        pcs
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic              v_q, d_q, x_q;
    logic [REG_W-1:0]  dst_q;
    logic [DATA_W-1:0] dat_q;
    logic [PC_W-1:0]   pc_q;
    logic              cmp_here;
    logic [DATA_W-1:0] cmp_d;
    logic              cmp_x;
    logic              alloc_here;
    logic              retire_here;

    // Merge the completion ports aimed at this slot; higher port wins a tie.
    always_comb begin
      cmp_here = 1'b0;
      cmp_d    = dat_q;
      cmp_x    = 1'b0;
      for (int p = 0; p < NCMP; p++) begin
        if (cmp_valid[p] && cmp_tag[p] == IDX_W'(e)) begin
          cmp_here = 1'b1;
          cmp_d    = cmp_data[p];
          cmp_x    = cmp_exc[p];
        end
      end
    end

    assign alloc_here  = do_alloc  && (tail == IDX_W'(e));
    assign retire_here = do_commit && (head == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        x_q <= 1'b0;
      end else if (do_flush) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        x_q <= 1'b0;
      end else if (alloc_here) begin
        v_q <= 1'b1;
        d_q <= 1'b0;
        x_q <= 1'b0;
      end else if (retire_here) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (cmp_here && v_q) begin
        d_q <= 1'b1;
        x_q <= cmp_x;
      end
    end

    // Payload carries no reset: it is only read behind the flags.
    always_ff @(posedge clk) begin
      if (alloc_here) begin
        dst_q <= alloc_dest;
        pc_q  <= alloc_pc;
      end
      if (cmp_here && v_q && !do_flush) dat_q <= cmp_d;
    end

    assign vld[e] = v_q;
    assign dne[e] = d_q;
    assign exc[e] = x_q;
    assign dst[e] = dst_q;
    assign dat[e] = dat_q;
    assign pcs[e] = pc_q;
  end

endmodule

// File: rtl/irb_lookup.sv
// One operand search: walk from oldest to youngest so the last match seen
// is the youngest producer.
module irb_lookup
  import irb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]             head,
  input  logic [DEPTH-1:0]             vld,
  input  logic [DEPTH-1:0]             dne,
  input  logic [DEPTH-1:0][REG_W-1:0]  dst,
  input  logic [DEPTH-1:0][DATA_W-1:0] dat,
  input  logic [REG_W-1:0]             src_reg,
  input  logic [DATA_W-1:0]            rf_data,
  output logic                         hit,
  output logic                         rdy,
  output logic [IDX_W-1:0]             tag,
  output logic [DATA_W-1:0]            value
);

  lookup_e           st;
  logic [DATA_W-1:0] found;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    st    = LK_MISS;
    tag   = '0;
    found = '0;
    idx   = head;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + IDX_W'(k);
      if (vld[idx] && dst[idx] == src_reg) begin
        tag   = idx;
        found = dat[idx];
        st    = dne[idx] ? LK_HIT : LK_WAIT;
      end
    end
  end

  assign hit   = (st != LK_MISS);
  assign rdy   = (st != LK_WAIT);
  assign value = (st == LK_HIT) ? found : rf_data;

endmodule

// File: rtl/inorder_retire_buf.sv
module inorder_retire_buf #(
  parameter int DEPTH  = 8,    // slots, power of two
  parameter int REG_W  = 5,    // register index width
  parameter int DATA_W = 32,   // result width
  parameter int PC_W   = 32,   // PC width
  parameter int NCMP   = 2,    // completion ports
  parameter int NSRC   = 2,    // operand lookup ports
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_valid,
  output logic                   alloc_ready,
  input  logic [REG_W-1:0]       alloc_dest,
  input  logic [PC_W-1:0]        alloc_pc,
  output logic [IDX_W-1:0]       alloc_tag,
  input  logic [NCMP-1:0]        cmp_valid,
  input  logic [NCMP*IDX_W-1:0]  cmp_tag,
  input  logic [NCMP*DATA_W-1:0] cmp_data,
  input  logic [NCMP-1:0]        cmp_exc,
  input  logic [NSRC*REG_W-1:0]  src_reg,
  input  logic [NSRC*DATA_W-1:0] src_rf_data,
  output logic [NSRC-1:0]        src_hit,
  output logic [NSRC-1:0]        src_ready,
  output logic [NSRC*IDX_W-1:0]  src_tag,
  output logic [NSRC*DATA_W-1:0] src_value,
  output logic                   commit_valid,
  input  logic                   commit_ready,
  output logic [REG_W-1:0]       commit_dest,
  output logic [DATA_W-1:0]      commit_data,
  output logic                   fault_valid,
  output logic [PC_W-1:0]        fault_pc
);

  logic [IDX_W-1:0]             head, tail;
  logic [CNT_W-1:0]             count;
  logic                         full;
  logic                         do_alloc, do_commit, do_flush;
  logic [DEPTH-1:0]             vld, dne, exc;
  logic [DEPTH-1:0][REG_W-1:0]  dst;
  logic [DEPTH-1:0][DATA_W-1:0] dat;
  logic [DEPTH-1:0][PC_W-1:0]   pcs;

  // Oldest-slot decisions: retire a clean result, or flush on a fault.
  assign commit_valid = vld[head] && dne[head] && !exc[head];
  assign fault_valid  = vld[head] && dne[head] &&  exc[head];
  assign commit_dest  = dst[head];
  assign commit_data  = dat[head];
  assign fault_pc     = pcs[head];

  assign alloc_ready  = !full && !fault_valid;
  assign alloc_tag    = tail;
  assign do_alloc     = alloc_valid && alloc_ready;
  assign do_commit    = commit_valid && commit_ready;
  assign do_flush     = fault_valid;

  irb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_alloc  (do_alloc),
    .do_commit (do_commit),
    .do_flush  (do_flush),
    .head      (head),
    .tail      (tail),
    .count     (count),
    .full      (full)
  );

  irb_store #(
    .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .PC_W(PC_W), .NCMP(NCMP)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .do_alloc   (do_alloc),
    .tail       (tail),
    .alloc_dest (alloc_dest),
    .alloc_pc   (alloc_pc),
    .cmp_valid  (cmp_valid),
    .cmp_tag    (cmp_tag),
    .cmp_data   (cmp_data),
    .cmp_exc    (cmp_exc),
    .do_commit  (do_commit),
    .head       (head),
    .do_flush   (do_flush),
    .vld        (vld),
    .dne        (dne),
    .exc        (exc),
    .dst        (dst),
    .dat        (dat),
    .pcs        (pcs)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    irb_lookup #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_lk (
      .head    (head),
      .vld     (vld),
      .dne     (dne),
      .dst     (dst),
      .dat     (dat),
      .src_reg (src_reg[s*REG_W +: REG_W]),
      .rf_data (src_rf_data[s*DATA_W +: DATA_W]),
      .hit     (src_hit[s]),
      .rdy     (src_ready[s]),
      .tag     (src_tag[s*IDX_W +: IDX_W]),
      .value   (src_value[s*DATA_W +: DATA_W])
    );
  end

endmodule

// File: rtl/irb_checker.sv
module irb_checker #(
  parameter int DEPTH  = 8,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              alloc_ready,
  input logic [IDX_W-1:0]  alloc_tag,
  input logic [CNT_W-1:0]  count,
  input logic [IDX_W-1:0]  head,
  input logic              commit_valid,
  input logic              commit_ready,
  input logic [REG_W-1:0]  commit_dest,
  input logic [DATA_W-1:0] commit_data,
  input logic              fault_valid
);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_full_refuses_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !alloc_ready);

  p_tag_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> alloc_tag == IDX_W'($past(alloc_tag) + 1'b1));

  p_retire_advances_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && commit_ready) |=> head == IDX_W'($past(head) + 1'b1));

  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !commit_ready) |=>
      (commit_valid && $stable(commit_dest) && $stable(commit_data) && $stable(head)));

  p_fault_no_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_valid && commit_valid));

  p_fault_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> (count == '0 && alloc_tag == '0 && !fault_valid));

endmodule

bind inorder_retire_buf irb_checker #(
  .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)
) u_irb_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_valid  (alloc_valid),
  .alloc_ready  (alloc_ready),
  .alloc_tag    (alloc_tag),
  .count        (count),
  .head         (head),
  .commit_valid (commit_valid),
  .commit_ready (commit_ready),
  .commit_dest  (commit_dest),
  .commit_data  (commit_data),
  .fault_valid  (fault_valid)
);

// File: tb/inorder_retire_buf_test.sv
module inorder_retire_buf_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid;
  logic        alloc_ready;
  logic [4:0]  alloc_dest;
  logic [31:0] alloc_pc;
  logic [2:0]  alloc_tag;
  logic [1:0]  cmp_valid;
  logic [5:0]  cmp_tag;
  logic [63:0] cmp_data;
  logic [1:0]  cmp_exc;
  logic [9:0]  src_reg;
  logic [63:0] src_rf_data;
  logic [1:0]  src_hit, src_ready;
  logic [5:0]  src_tag;
  logic [63:0] src_value;
  logic        commit_valid, commit_ready;
  logic [4:0]  commit_dest;
  logic [31:0] commit_data;
  logic        fault_valid;
  logic [31:0] fault_pc;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Register-file stand-in: a fixed pattern tagged with the register index.
  function automatic logic [31:0] rf_of(input logic [4:0] r);
    return 32'hB4B4B4A0 | {27'd0, r};
  endfunction

  assign src_rf_data = {rf_of(src_reg[9:5]), rf_of(src_reg[4:0])};

  inorder_retire_buf uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_dest(alloc_dest),
    .alloc_pc(alloc_pc), .alloc_tag(alloc_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
    .src_reg(src_reg), .src_rf_data(src_rf_data), .src_hit(src_hit),
    .src_ready(src_ready), .src_tag(src_tag), .src_value(src_value),
    .commit_valid(commit_valid), .commit_ready(commit_ready),
    .commit_dest(commit_dest), .commit_data(commit_data),
    .fault_valid(fault_valid), .fault_pc(fault_pc)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = 1'b0; alloc_dest = '0; alloc_pc = '0;
    cmp_valid = '0; cmp_tag = '0; cmp_data = '0; cmp_exc = '0;
    commit_ready = 1'b0; src_reg = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic alloc_one(input logic [4:0] d, input logic [31:0] pc, input logic [2:0] exp_tag);
    idle();
    alloc_valid = 1'b1; alloc_dest = d; alloc_pc = pc;
    #1;
    chk("R2 ready to allocate", 32'(alloc_ready), 32'd1);
    chk("R2 tag order", 32'(alloc_tag), 32'(exp_tag));
    @(negedge clk);
  endtask

  // One row per cycle: stimulus, then the outputs expected before that edge.
  typedef struct packed {
    logic        av;  logic [4:0] ad;
    logic        cv;  logic [2:0] ct;  logic [31:0] cd;
    logic        cr;  logic [4:0] sr;
    logic [2:0]  e_atag;
    logic        e_cv; logic [4:0] e_cdst; logic [31:0] e_cdat;
    logic        e_hit; logic e_rdy; logic [2:0] e_stag; logic [31:0] e_val;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd3, 1'b0, 3'd0, 32'h0,  1'b0, 5'd3, 3'd0, 1'b0, 5'd0, 32'h0,  1'b0, 1'b1, 3'd0, 32'hB4B4B4A3},
    '{1'b1, 5'd4, 1'b0, 3'd0, 32'h0,  1'b0, 5'd3, 3'd1, 1'b0, 5'd0, 32'h0,  1'b1, 1'b0, 3'd0, 32'h0},
    '{1'b1, 5'd3, 1'b1, 3'd1, 32'h44, 1'b0, 5'd4, 3'd2, 1'b0, 5'd0, 32'h0,  1'b1, 1'b0, 3'd1, 32'h0},
    '{1'b0, 5'd0, 1'b1, 3'd2, 32'h33, 1'b0, 5'd3, 3'd3, 1'b0, 5'd0, 32'h0,  1'b1, 1'b0, 3'd2, 32'h0},
    '{1'b0, 5'd0, 1'b1, 3'd0, 32'h30, 1'b0, 5'd3, 3'd3, 1'b0, 5'd0, 32'h0,  1'b1, 1'b1, 3'd2, 32'h33},
    '{1'b0, 5'd0, 1'b0, 3'd0, 32'h0,  1'b0, 5'd3, 3'd3, 1'b1, 5'd3, 32'h30, 1'b1, 1'b1, 3'd2, 32'h33},
    '{1'b0, 5'd0, 1'b0, 3'd0, 32'h0,  1'b1, 5'd4, 3'd3, 1'b1, 5'd3, 32'h30, 1'b1, 1'b1, 3'd1, 32'h44},
    '{1'b0, 5'd0, 1'b0, 3'd0, 32'h0,  1'b1, 5'd4, 3'd3, 1'b1, 5'd4, 32'h44, 1'b1, 1'b1, 3'd1, 32'h44},
    '{1'b0, 5'd0, 1'b0, 3'd0, 32'h0,  1'b1, 5'd4, 3'd3, 1'b1, 5'd3, 32'h33, 1'b0, 1'b1, 3'd0, 32'hB4B4B4A4},
    '{1'b1, 5'd7, 1'b0, 3'd0, 32'h0,  1'b0, 5'd3, 3'd3, 1'b0, 5'd0, 32'h0,  1'b0, 1'b1, 3'd0, 32'hB4B4B4A3},
    '{1'b0, 5'd0, 1'b0, 3'd0, 32'h0,  1'b0, 5'd7, 3'd4, 1'b0, 5'd0, 32'h0,  1'b1, 1'b0, 3'd3, 32'h0}
  };

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    do_reset();
    src_reg = {5'd7, 5'd3};
    #1;
    chk("R1 reset alloc_ready", 32'(alloc_ready), 32'd1);
    chk("R1 reset alloc_tag", 32'(alloc_tag), 32'd0);
    chk("R1 reset commit_valid", 32'(commit_valid), 32'd0);
    chk("R1 reset fault_valid", 32'(fault_valid), 32'd0);
    chk("R1 reset lookup miss", 32'(src_hit), 32'd0);
    @(negedge clk);

    // Vector table: two producers of r3, late completion, stalled retirement.
    for (int i = 0; i < NV; i++) begin
      idle();
      alloc_valid  = VEC[i].av;
      alloc_dest   = VEC[i].ad;
      alloc_pc     = 32'h1000 + 32'(i * 4);
      cmp_valid    = {1'b0, VEC[i].cv};
      cmp_tag      = {3'd0, VEC[i].ct};
      cmp_data     = {32'd0, VEC[i].cd};
      commit_ready = VEC[i].cr;
      src_reg      = {5'd0, VEC[i].sr};
      #1;
      chk($sformatf("R2 row %0d alloc_tag", i), 32'(alloc_tag), 32'(VEC[i].e_atag));
      chk($sformatf("%s row %0d commit_valid", VEC[i].cr ? "R5" : "R6", i),
          32'(commit_valid), 32'(VEC[i].e_cv));
      if (VEC[i].e_cv) begin
        chk($sformatf("R5 row %0d commit_dest", i), 32'(commit_dest), 32'(VEC[i].e_cdst));
        chk($sformatf("R5 row %0d commit_data", i), commit_data, VEC[i].e_cdat);
      end
      chk($sformatf("R7/R10 row %0d src_hit", i), 32'(src_hit[0]), 32'(VEC[i].e_hit));
      chk($sformatf("R7/R10 row %0d src_ready", i), 32'(src_ready[0]), 32'(VEC[i].e_rdy));
      if (VEC[i].e_hit)
        chk($sformatf("R7 row %0d src_tag", i), 32'(src_tag[2:0]), 32'(VEC[i].e_stag));
      if (VEC[i].e_rdy)
        chk($sformatf("%s row %0d src_value", VEC[i].e_hit ? "R7" : "R8", i),
            src_value[31:0], VEC[i].e_val);
      @(negedge clk);
    end

    // Reset from a non-empty state.
    do_reset();
    src_reg = {5'd3, 5'd7};
    #1;
    chk("R1 reset clears r7 producer", 32'(src_hit), 32'd0);
    chk("R1 reset commit_valid", 32'(commit_valid), 32'd0);
    @(negedge clk);

    // R4: completion to an empty slot is dropped.
    idle();
    cmp_valid = 2'b01; cmp_tag = 6'd5; cmp_data = {32'd0, 32'h55};
    @(negedge clk);
    for (int i = 0; i < 6; i++) alloc_one(5'(10 + i), 32'h300 + 32'(4 * i), 3'(i));
    idle();
    src_reg = {5'd15, 5'd0};
    #1;
    chk("R4 stray completion ignored hit", 32'(src_hit[1]), 32'd1);
    chk("R4 stray completion ignored tag", 32'(src_tag[5:3]), 32'd5);
    chk("R4 stray completion ignored ready", 32'(src_ready[1]), 32'd0);
    @(negedge clk);

    // R4 / R10: two completions out of order in one cycle.
    idle();
    cmp_valid = 2'b11; cmp_tag = {3'd2, 3'd4}; cmp_data = {32'h200, 32'h400};
    src_reg = {5'd12, 5'd14};
    #1;
    chk("R10 same-cycle completion not yet visible", 32'(src_ready), 32'd0);
    @(negedge clk);
    idle();
    src_reg = {5'd12, 5'd14};
    #1;
    chk("R4 port0 result stored", src_value[31:0], 32'h400);
    chk("R4 port1 result stored", src_value[63:32], 32'h200);
    chk("R4 both ready", 32'(src_ready), 32'd3);
    chk("R5 head unfinished blocks retire", 32'(commit_valid), 32'd0);
    @(negedge clk);

    // R3: fill, refuse, and no same-cycle reuse of a retiring slot.
    alloc_one(5'd16, 32'h318, 3'd6);
    alloc_one(5'd17, 32'h31C, 3'd7);
    idle();
    alloc_valid = 1'b1; alloc_dest = 5'd30;
    #1;
    chk("R3 full refuses", 32'(alloc_ready), 32'd0);
    chk("R3 tag wrapped", 32'(alloc_tag), 32'd0);
    @(negedge clk);
    idle();
    src_reg = {5'd30, 5'd10};
    cmp_valid = 2'b01; cmp_tag = 6'd0; cmp_data = {32'd0, 32'hA0};
    #1;
    chk("R3 refused alloc kept slot 0", 32'(src_hit[0]), 32'd1);
    chk("R3 refused alloc kept slot 0 tag", 32'(src_tag[2:0]), 32'd0);
    chk("R3 refused alloc not stored", 32'(src_hit[1]), 32'd0);
    @(negedge clk);
    idle();
    commit_ready = 1'b1;
    #1;
    chk("R5 oldest retires", 32'(commit_valid), 32'd1);
    chk("R5 oldest dest", 32'(commit_dest), 32'd10);
    chk("R5 oldest data", commit_data, 32'hA0);
    chk("R3 slot not freed same cycle", 32'(alloc_ready), 32'd0);
    @(negedge clk);
    idle();
    commit_ready = 1'b1;
    #1;
    chk("R3 slot freed next cycle", 32'(alloc_ready), 32'd1);
    chk("R3 freed slot tag", 32'(alloc_tag), 32'd0);
    chk("R5 done younger waits for head", 32'(commit_valid), 32'd0);
    @(negedge clk);

    // R9: faulting oldest entry flushes.
    do_reset();
    @(negedge clk);
    for (int i = 0; i < 3; i++) alloc_one(5'(1 + i), 32'h100 + 32'(4 * i), 3'(i));
    idle();
    cmp_valid = 2'b11; cmp_tag = {3'd0, 3'd1}; cmp_data = {32'd0, 32'h11}; cmp_exc = 2'b10;
    @(negedge clk);
    idle();
    cmp_valid = 2'b01; cmp_tag = 6'd2; cmp_data = {32'd0, 32'h22};
    alloc_valid = 1'b1; alloc_dest = 5'd9; commit_ready = 1'b1;
    #1;
    chk("R9 fault reported", 32'(fault_valid), 32'd1);
    chk("R9 fault pc", fault_pc, 32'h100);
    chk("R9 no retire on fault", 32'(commit_valid), 32'd0);
    chk("R9 alloc refused on fault", 32'(alloc_ready), 32'd0);
    @(negedge clk);
    idle();
    src_reg = {5'd9, 5'd2};
    #1;
    chk("R9 fault one cycle", 32'(fault_valid), 32'd0);
    chk("R9 tag back to zero", 32'(alloc_tag), 32'd0);
    chk("R9 younger result discarded", 32'(src_hit), 32'd0);
    chk("R8 miss returns register file", src_value[31:0], rf_of(5'd2));
    chk("R8 miss ready", 32'(src_ready), 32'd3);
    @(negedge clk);

    // R9: younger exception waits until it is oldest.
    alloc_one(5'd3, 32'h200, 3'd0);
    alloc_one(5'd5, 32'h204, 3'd1);
    idle();
    cmp_valid = 2'b01; cmp_tag = 6'd1; cmp_exc = 2'b01;
    @(negedge clk);
    idle();
    #1;
    chk("R9 younger exception deferred", 32'(fault_valid), 32'd0);
    @(negedge clk);
    idle();
    cmp_valid = 2'b01; cmp_tag = 6'd0; cmp_data = {32'd0, 32'h77};
    @(negedge clk);
    idle();
    commit_ready = 1'b1;
    #1;
    chk("R5 clean head retires before fault", 32'(commit_valid), 32'd1);
    chk("R5 clean head data", commit_data, 32'h77);
    chk("R9 no fault while head clean", 32'(fault_valid), 32'd0);
    @(negedge clk);
    idle();
    #1;
    chk("R9 deferred fault reported", 32'(fault_valid), 32'd1);
    chk("R9 deferred fault pc", fault_pc, 32'h204);
    @(negedge clk);
    idle();
    #1;
    chk("R9 empty after deferred fault", 32'(alloc_tag), 32'd0);
    chk("R9 no retire after flush", 32'(commit_valid), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule